// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two predictors run side by side. The first is a per-branch predictor: a table, indexed by fetch address, holds each branch's own recent outcome pattern, and that pattern selects a saturating counter. The second is a global predictor: a shift register records the latest resolved outcomes of all branches, and it indexes a table of 2-bit saturating counters. A third table of 2-bit counters, also indexed by the global history, decides for each lookup which of the two answers is the final prediction.

The lookup port takes a fetch PC. In the same cycle it returns the final prediction, both component predictions, the chooser's pick and the two history values the lookup used. The front end keeps these values with the branch. When the branch resolves, the front end sends them back through the update port with the real outcome. The update then trains the local history, the local counter, the global counter and the chooser, and it shifts the outcome into the global history. The block takes one lookup and one update each cycle.

Top module: `tourn_bp`

## Requirements
- R1: Lookup outputs are combinational from `lk_pc` in the same cycle. `lk_taken` equals `lk_global_taken` when `lk_use_global` is 1, and `lk_local_taken` otherwise.
- R2: A table of per-branch histories is indexed by `PC[11:2]`. `lk_lhist` returns the indexed entry. An update shifts `up_taken` into the entry at `up_pc[11:2]` at bit 0, and the oldest bit drops out.
- R3: The local counters are 3-bit saturating counters indexed by `up_lhist`. An update moves the counter up on taken and down on not-taken, and it stops at 7 and at 0. The counter MSB is `lk_local_taken`.
- R4: The global table has 4096 entries of 2-bit saturating counters, indexed by the 12-bit global history (`up_ghist` on update). Each counter stops at 3 and at 0. The counter MSB is `lk_global_taken`.
- R5: Each update shifts `up_taken` into bit 0 of the global history register, which `lk_ghist` shows.
- R6: The chooser counter at `up_ghist` changes only when `up_local_taken` differs from `up_global_taken`. It moves up, toward global, when the global prediction matched `up_taken`, and down otherwise. It saturates at 3 and at 0, and its MSB is `lk_use_global`.
- R7: After reset, all local and global counters read 3, then 1 (weakly not-taken). The chooser reads 1 (weakly prefer local). Both histories read zero.
- R8: When a lookup and an update hit the same entries in one cycle, the lookup returns the values from before the update.
- R9: While `up_valid` is 0, no table or history changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_taken | output | 1 | Final direction prediction |
| lk_local_taken | output | 1 | Local component prediction |
| lk_global_taken | output | 1 | Global component prediction |
| lk_use_global | output | 1 | Chooser pick (1 = global) |
| lk_lhist | output | 10 | Local history used by this lookup |
| lk_ghist | output | 12 | Global history used by this lookup |
| up_valid | input | 1 | Update strobe |
| up_pc | input | 32 | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome |
| up_lhist | input | 10 | Saved local history of that branch |
| up_ghist | input | 12 | Saved global history of that branch |
| up_local_taken | input | 1 | Saved local prediction |
| up_global_taken | input | 1 | Saved global prediction |

## Verification
The bench runs several kinds of branch stream. A long run of taken branches at one address drives the local and global counters to their upper limits, and a later run of not-taken branches drives them back to zero. Together these show that saturation works at both ends. A strictly alternating branch fills its history with a repeating pattern, so the local component learns it while the global and chooser counters disagree. This shows whether the chooser trains only on disagreement. Each update is paired with a same-cycle lookup at the same address to expose any bypass of pre-update values. A stream of pseudo-random outcomes over eight addresses, with idle cycles that carry junk update fields, exercises mixed indexing and confirms that an update without its strobe has no effect.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
   // Chooser decision encoding: counter MSB set selects the global answer.
   typedef enum logic {
      PICK_LOCAL  = 1'b0,
      PICK_GLOBAL = 1'b1
   } tbp_pick_e;

   localparam int unsigned TBP_MAX_HIST_W = 16;
   localparam int unsigned TBP_MIN_CTR_W  = 2;
endpackage

// File: rtl/tbp_sat_step.sv
module tbp_sat_step #(
   parameter int unsigned W = 2
) (
   input  logic [W-1:0] cur,
   input  logic         inc,
   output logic [W-1:0] nxt
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   always_comb begin
      if (inc) begin
         nxt = (&cur) ? cur : cur + ONE;
      end else begin
         nxt = (|cur) ? cur - ONE : cur;
      end
   end
endmodule

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
   parameter int unsigned IDX_W = 12,
   parameter int unsigned CTR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CTR_W-1:0] rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_inc
);
   localparam int unsigned   DEPTH = 1 << IDX_W;
   localparam logic [CTR_W-1:0] WEAK_LOW = {1'b0, {(CTR_W-1){1'b1}}};

   logic [CTR_W-1:0] ctr_q [DEPTH];
   logic [CTR_W-1:0] ctr_nxt;

   assign rd_ctr = ctr_q[rd_idx];

   tbp_sat_step #(.W(CTR_W)) u_step (
      .cur (ctr_q[wr_idx]),
      .inc (wr_inc),
      .nxt (ctr_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            ctr_q[i] <= WEAK_LOW;
         end
      end else if (wr_en) begin
         ctr_q[wr_idx] <= ctr_nxt;
      end
   end
endmodule

// File: rtl/tbp_local.sv
module tbp_local #(
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned HIST_W = 10,
   parameter int unsigned CTR_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  lk_idx,
   output logic [HIST_W-1:0] lk_hist,
   output logic              lk_pred,
   input  logic              up_valid,
   input  logic [IDX_W-1:0]  up_idx,
   input  logic [HIST_W-1:0] up_hist,
   input  logic              up_taken
);
   localparam int unsigned HT_DEPTH = 1 << IDX_W;

   logic [HIST_W-1:0] hist_q [HT_DEPTH];
   logic [CTR_W-1:0]  pat_ctr;

   assign lk_hist = hist_q[lk_idx];

   // Pattern counters selected by the history value.
   tbp_ctr_table #(.IDX_W(HIST_W), .CTR_W(CTR_W)) u_pat (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (lk_hist),
      .rd_ctr (pat_ctr),
      .wr_en  (up_valid),
      .wr_idx (up_hist),
      .wr_inc (up_taken)
   );

   assign lk_pred = pat_ctr[CTR_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < HT_DEPTH; i++) begin
            hist_q[i] <= '0;
         end
      end else if (up_valid) begin
         hist_q[up_idx] <= {hist_q[up_idx][HIST_W-2:0], up_taken};
      end
   end
endmodule

// File: rtl/tbp_ghist.sv
module tbp_ghist #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         bit_in,
   output logic [W-1:0] hist
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
      end else if (shift_en) begin
         hist <= {hist[W-2:0], bit_in};
      end
   end
endmodule

// File: rtl/tourn_bp.sv
module tourn_bp
   import tbp_pkg::*;
#(
   parameter int unsigned PC_W        = 32,
   parameter int unsigned PC_LSB      = 2,
   parameter int unsigned LHT_IDX_W   = 10,
   parameter int unsigned LHIST_W     = 10,
   parameter int unsigned LCTR_W      = 3,
   parameter int unsigned GHIST_W     = 12,
   parameter int unsigned GCTR_W      = 2,
   parameter int unsigned CCTR_W      = 2,
   parameter bit          GIDX_XOR_PC = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PC_W-1:0]    lk_pc,
   output logic               lk_taken,
   output logic               lk_local_taken,
   output logic               lk_global_taken,
   output logic               lk_use_global,
   output logic [LHIST_W-1:0] lk_lhist,
   output logic [GHIST_W-1:0] lk_ghist,
   input  logic               up_valid,
   input  logic [PC_W-1:0]    up_pc,
   input  logic               up_taken,
   input  logic [LHIST_W-1:0] up_lhist,
   input  logic [GHIST_W-1:0] up_ghist,
   input  logic               up_local_taken,
   input  logic               up_global_taken
);
   // Elaboration-time parameter checks.
   if (PC_W < PC_LSB + LHT_IDX_W) begin : g_bad_pc_local
      $error("tourn_bp: PC_W too narrow for local index");
   end
   if (GIDX_XOR_PC && (PC_W < PC_LSB + GHIST_W)) begin : g_bad_pc_global
      $error("tourn_bp: PC_W too narrow for hashed global index");
   end
   if (LHIST_W < 2 || LHIST_W > TBP_MAX_HIST_W) begin : g_bad_lhist
      $error("tourn_bp: LHIST_W out of range");
   end
   if (GHIST_W < 2 || GHIST_W > TBP_MAX_HIST_W) begin : g_bad_ghist
      $error("tourn_bp: GHIST_W out of range");
   end
   if (LCTR_W < TBP_MIN_CTR_W || GCTR_W < TBP_MIN_CTR_W || CCTR_W < TBP_MIN_CTR_W) begin : g_bad_ctr
      $error("tourn_bp: counter widths must be at least 2");
   end

   logic [LHT_IDX_W-1:0] lk_lidx, up_lidx;
   logic [GHIST_W-1:0]   lk_gidx, up_gidx;
   logic [GCTR_W-1:0]    g_ctr;
   logic [CCTR_W-1:0]    c_ctr;
   logic                 ch_wr_en;
   logic                 ch_toward_global;
   tbp_pick_e            pick;
   logic                 unused_pc_bits;

   assign lk_lidx = lk_pc[PC_LSB +: LHT_IDX_W];
   assign up_lidx = up_pc[PC_LSB +: LHT_IDX_W];
   assign unused_pc_bits = ^{lk_pc, up_pc};

   // Global index variant: plain history or history folded with PC bits.
   if (GIDX_XOR_PC) begin : g_gidx_hash
      assign lk_gidx = lk_ghist ^ lk_pc[PC_LSB +: GHIST_W];
      assign up_gidx = up_ghist ^ up_pc[PC_LSB +: GHIST_W];
   end else begin : g_gidx_plain
      assign lk_gidx = lk_ghist;
      assign up_gidx = up_ghist;
   end

   tbp_local #(
      .IDX_W  (LHT_IDX_W),
      .HIST_W (LHIST_W),
      .CTR_W  (LCTR_W)
   ) u_local (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_idx   (lk_lidx),
      .lk_hist  (lk_lhist),
      .lk_pred  (lk_local_taken),
      .up_valid (up_valid),
      .up_idx   (up_lidx),
      .up_hist  (up_lhist),
      .up_taken (up_taken)
   );

   tbp_ghist #(.W(GHIST_W)) u_ghist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (up_valid),
      .bit_in   (up_taken),
      .hist     (lk_ghist)
   );

   tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_gtab (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (lk_gidx),
      .rd_ctr (g_ctr),
      .wr_en  (up_valid),
      .wr_idx (up_gidx),
      .wr_inc (up_taken)
   );
   assign lk_global_taken = g_ctr[GCTR_W-1];

   // Chooser trains only when the two components disagreed.
   assign ch_wr_en         = up_valid && (up_local_taken != up_global_taken);
   assign ch_toward_global = (up_global_taken == up_taken);

   tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CCTR_W)) u_chooser (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (lk_ghist),
      .rd_ctr (c_ctr),
      .wr_en  (ch_wr_en),
      .wr_idx (up_ghist),
      .wr_inc (ch_toward_global)
   );

   assign pick          = tbp_pick_e'(c_ctr[CCTR_W-1]);
   assign lk_use_global = (pick == PICK_GLOBAL);
   assign lk_taken      = (pick == PICK_GLOBAL) ? lk_global_taken : lk_local_taken;
endmodule

// File: rtl/tourn_bp_chk.sv
module tourn_bp_chk #(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned PC_LSB    = 2,
   parameter int unsigned LHT_IDX_W = 10,
   parameter int unsigned LHIST_W   = 10,
   parameter int unsigned GHIST_W   = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PC_W-1:0]    lk_pc,
   input logic               lk_taken,
   input logic               lk_local_taken,
   input logic               lk_global_taken,
   input logic               lk_use_global,
   input logic [LHIST_W-1:0] lk_lhist,
   input logic [GHIST_W-1:0] lk_ghist,
   input logic               up_valid,
   input logic [PC_W-1:0]    up_pc,
   input logic               up_taken
);
   logic [LHT_IDX_W-1:0] lk_i, up_i;
   assign lk_i = lk_pc[PC_LSB +: LHT_IDX_W];
   assign up_i = up_pc[PC_LSB +: LHT_IDX_W];

   p_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({lk_taken, lk_use_global, lk_local_taken, lk_global_taken}));

   p_agree_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_local_taken == lk_global_taken) |-> (lk_taken == lk_local_taken));

   p_lhist_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && (lk_i == up_i)) |=>
         ((lk_i != $past(lk_i)) ||
          (lk_lhist == {$past(lk_lhist[LHIST_W-2:0]), $past(up_taken)})));

   p_ghist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |=> (lk_ghist == {$past(lk_ghist[GHIST_W-2:0]), $past(up_taken)}));

   p_ghist_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (lk_ghist == '0));

   p_ghist_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |=> $stable(lk_ghist));
endmodule

bind tourn_bp tourn_bp_chk #(
   .PC_W      (PC_W),
   .PC_LSB    (PC_LSB),
   .LHT_IDX_W (LHT_IDX_W),
   .LHIST_W   (LHIST_W),
   .GHIST_W   (GHIST_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .lk_pc           (lk_pc),
   .lk_taken        (lk_taken),
   .lk_local_taken  (lk_local_taken),
   .lk_global_taken (lk_global_taken),
   .lk_use_global   (lk_use_global),
   .lk_lhist        (lk_lhist),
   .lk_ghist        (lk_ghist),
   .up_valid        (up_valid),
   .up_pc           (up_pc),
   .up_taken        (up_taken)
);

// File: tb/tourn_bp_tb.sv
module tourn_bp_tb;
   localparam int CLK_PER = 10;
   localparam int LHN = 1024;
   localparam int GHN = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_taken, lk_local_taken, lk_global_taken, lk_use_global;
   logic [9:0]  lk_lhist;
   logic [11:0] lk_ghist;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic        up_taken = 1'b0;
   logic [9:0]  up_lhist = '0;
   logic [11:0] up_ghist = '0;
   logic        up_local_taken = 1'b0;
   logic        up_global_taken = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   tourn_bp u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .lk_pc           (lk_pc),
      .lk_taken        (lk_taken),
      .lk_local_taken  (lk_local_taken),
      .lk_global_taken (lk_global_taken),
      .lk_use_global   (lk_use_global),
      .lk_lhist        (lk_lhist),
      .lk_ghist        (lk_ghist),
      .up_valid        (up_valid),
      .up_pc           (up_pc),
      .up_taken        (up_taken),
      .up_lhist        (up_lhist),
      .up_ghist        (up_ghist),
      .up_local_taken  (up_local_taken),
      .up_global_taken (up_global_taken)
   );

   typedef struct {
      bit    taken;
      bit    loc;
      bit    glb;
      bit    useg;
      int    lhist;
      int    ghist;
      string tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // Independent reference state built from the requirements.
   int m_lht[LHN];
   int m_lpt[LHN];
   int m_gpt[GHN];
   int m_cht[GHN];
   int m_gh;

   function automatic int sat(int v, bit up, int mx);
      if (up) return (v < mx) ? v + 1 : v;
      return (v > 0) ? v - 1 : v;
   endfunction

   function automatic exp_t model_lookup(int pc, string tag);
      exp_t e;
      e.lhist = m_lht[(pc >> 2) & (LHN-1)];
      e.ghist = m_gh;
      e.loc   = (m_lpt[e.lhist] >= 4);
      e.glb   = (m_gpt[e.ghist] >= 2);
      e.useg  = (m_cht[e.ghist] >= 2);
      e.taken = e.useg ? e.glb : e.loc;
      e.tag   = tag;
      return e;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver: one cycle of lookup plus optional update; pushes expectation.
   task automatic drive(int pc, bit uv, int upc, bit ut, int ulh, int ugh,
                        bit ult, bit ugt, string tag);
      exp_t e;
      @(negedge clk);
      lk_pc           = 32'(pc);
      up_valid        = uv;
      up_pc           = 32'(upc);
      up_taken        = ut;
      up_lhist        = 10'(ulh);
      up_ghist        = 12'(ugh);
      up_local_taken  = ult;
      up_global_taken = ugt;
      e = model_lookup(pc, tag);   // R8: lookup sees pre-update state
      q.push_back(e);
      if (uv) begin
         int li;
         li = (upc >> 2) & (LHN-1);
         m_lht[li]  = ((m_lht[li] << 1) | int'(ut)) & (LHN-1);
         m_lpt[ulh] = sat(m_lpt[ulh], ut, 7);
         m_gpt[ugh] = sat(m_gpt[ugh], ut, 3);
         if (ult != ugt) m_cht[ugh] = sat(m_cht[ugh], (ugt == ut), 3);
         m_gh = ((m_gh << 1) | int'(ut)) & (GHN-1);
      end
   endtask

   // A branch: lookup cycle, then resolve it with a same-cycle lookup.
   task automatic branch(int pc, bit t, string tag);
      exp_t s;
      s = model_lookup(pc, tag);
      drive(pc, 0, 0, 0, 0, 0, 0, 0, tag);
      drive(pc, 1, pc, t, s.lhist, s.ghist, s.loc, s.glb, {tag, "/R8"});
   endtask

   // Monitor: compares outputs a quarter period after the driving edge.
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PER/4);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " R1 final"},  int'(lk_taken),        int'(e.taken));
            check({e.tag, " R3 local"},  int'(lk_local_taken),  int'(e.loc));
            check({e.tag, " R4 global"}, int'(lk_global_taken), int'(e.glb));
            check({e.tag, " R6 pick"},   int'(lk_use_global),   int'(e.useg));
            check({e.tag, " R2 lhist"},  int'(lk_lhist),        e.lhist);
            check({e.tag, " R5 ghist"},  int'(lk_ghist),        e.ghist);
         end
      end
   end

   initial begin
      #(CLK_PER * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int lfsr;
      for (int i = 0; i < LHN; i++) begin m_lht[i] = 0; m_lpt[i] = 3; end
      for (int i = 0; i < GHN; i++) begin m_gpt[i] = 1; m_cht[i] = 1; end
      m_gh = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R7: reset state seen through lookups at two addresses.
      drive(32'h0, 0, 0, 0, 0, 0, 0, 0, "R7");
      drive(32'h3ffc, 0, 0, 0, 0, 0, 0, 0, "R7");

      // R3/R4: taken streak saturates counters upward.
      for (int i = 0; i < 20; i++) branch(32'h100, 1, "R3up");

      // R2/R6: alternating branch trains local pattern, chooser on disagreement.
      for (int i = 0; i < 30; i++) branch(32'h204, (i % 2) == 1, "R6alt");

      // R9: strobe low with junk update fields.
      for (int i = 0; i < 4; i++)
         drive(32'h100, 0, 32'h100, 1, 10'h3ff, 12'hfff, 1, 0, "R9");
      drive(32'h204, 0, 0, 0, 0, 0, 0, 0, "R9");

      // R3/R4: not-taken streak saturates counters at zero.
      for (int i = 0; i < 24; i++) branch(32'h100, 0, "R3down");

      // R1: pseudo-random outcomes over eight addresses.
      lfsr = 16'hace1;
      for (int i = 0; i < 300; i++) begin
         lfsr = ((lfsr >> 1) | ((((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hffff;
         branch(32'h400 + ((lfsr & 7) << 2), (lfsr >> 4) & 1, "R1mix");
         if ((lfsr & 31) == 0) drive(32'h400, 0, 32'h404, 1, 5, 9, 0, 1, "R9");
      end

      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule